// File: doc/BRIEF.md
# Join-Point Misprediction Recovery Tracker

This block sits beside the decoder and watches for a short forward conditional branch whose two paths meet again at a point the decoder has found. The branch is still predicted in the usual way. After such a branch, the tracker labels each decoded instruction. Instructions up to the meeting point are labelled as predicted-path. Instructions from the meeting point on are labelled as shared join region. It keeps these labels in a window of slots, indexed by order after the branch.

A misprediction can arrive after decode has already passed the meeting point. In that case the tracker does not start a full flush. It raises a one-cycle nullify mask over exactly the predicted-path slots. It then asks for the alternate-path instructions to be inserted, and holds the join region until the insertion is accepted.

A misprediction that arrives before the meeting point forces a full recovery instead. So does a second conditional branch inside the shadow, a misprediction of an untracked branch, or a shadow longer than the window allows. Only one branch shadow is followed at a time.

The controller has six states:
- IDLE: no shadow is being followed.
- SHADOW: counting predicted-path instructions.
- JOINED: the meeting point has been reached and join-region instructions are being counted.
- NULLIFY: one cycle, the nullify mask is shown.
- INSERT: the insert request waits for acceptance.
- RECOVER: one cycle, the full-recovery pulse.

The state transitions are:
- IDLE to SHADOW: a qualifying branch with a non-zero path length.
- IDLE to JOINED: a qualifying branch with a zero path length.
- IDLE to RECOVER: a mispredicted resolve.
- SHADOW to JOINED: the last predicted-path instruction is decoded.
- SHADOW to RECOVER: a mispredicted resolve, or a second conditional branch.
- SHADOW to IDLE: a correct resolve.
- JOINED to NULLIFY: a mispredicted resolve.
- JOINED to IDLE: a correct resolve.
- NULLIFY to INSERT: the alternate path is not empty.
- NULLIFY to IDLE: the alternate path is empty.
- INSERT to IDLE: the insert is acknowledged.
- RECOVER to IDLE: always, after one cycle.

Top module: `jp_repair_tracker`

## Requirements
- R1: After reset, all slot tags are 2'b00 (unrelated) and the nullify mask, insert request, insert count, hold and full-recovery outputs are all zero.
- R2: A decoded conditional branch with predicted-path length 1..8 and alternate length 0..8 starts tracking. Each following decoded instruction, up to that length, sets its slot tag to 2'b01 (predicted). Slot 0 is the first instruction after the branch, and slot k occupies bits 2k+1:2k of slot_tags. The tag appears in the cycle after the instruction's edge.
- R3: Once the predicted path is complete, each further decoded instruction sets the next slot to 2'b10 (join region). This continues until all 16 slots are used; later instructions are not tagged.
- R4: A mispredicted resolve after the meeting point produces, one cycle later, a one-cycle nullify mask. The mask has bit k set exactly for the predicted-path slots, and join_hold is high in that cycle.
- R5: The cycle after the nullify, ins_req rises with ins_count equal to the alternate length, and join_hold stays high. Both are held until ins_ack is sampled; then all outputs and tags return to zero.
- R6: With an alternate length of 0, no insert request follows the nullify cycle and the block returns to idle.
- R7: A mispredicted resolve before the meeting point raises full_recover for one cycle, with no nullify and all tags cleared.
- R8: A second conditional branch decoded inside the predicted-path shadow abandons tracking and raises full_recover for one cycle.
- R9: A branch with predicted or alternate length above 8 is not tracked. Its instructions stay tagged 2'b00.
- R10: A correct resolve while tracking clears all tags, with no nullify and no full_recover.
- R11: A mispredicted resolve while idle raises full_recover for one cycle.
- R12: While the insert request is pending, new branches and resolves are ignored. After acceptance, the next decoded instruction is untagged.
- R13: A qualifying branch with predicted length 0 goes straight to the join region. On misprediction the nullify mask is zero, but join_hold and the insertion still follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is decoded this cycle |
| dec_cbr | input | 1 | The decoded instruction is a forward conditional branch |
| dec_pred_len | input | LEN_W | Instructions on the predicted path before the meeting point |
| dec_alt_len | input | LEN_W | Instructions on the alternate path |
| res_valid | input | 1 | A branch resolves this cycle |
| res_mispredict | input | 1 | The resolving branch was mispredicted |
| ins_ack | input | 1 | Alternate-path insertion accepted |
| slot_tags | output | 2*DEPTH | Per-slot 2-bit tag, slot k at bits 2k+1:2k |
| nullify_mask | output | DEPTH | One-cycle mask of slots to nullify |
| ins_req | output | 1 | Request to insert the alternate path |
| ins_count | output | LEN_W | Number of instructions to insert |
| join_hold | output | 1 | Hold the join-region instructions |
| full_recover | output | 1 | One-cycle request for a full flush and refetch |

## Verification
The hardest situation to reach is a misprediction that lands after the meeting point, while the join region has already filled the window. Every slot is used, and the mask must then cover exactly the predicted half. The stimulus gets there by decoding a full eight-instruction shadow, then ten join instructions, before resolving the branch. This shows both that the mask is correct and that the join count stops at the window edge. A branch and a resolve arriving during a pending insert are the second hard case. They are driven in the same cycle while the acknowledge is held low, and the bench then shows that neither was taken up.

// File: rtl/jp_pkg.sv
package jp_pkg;

    typedef enum logic [1:0] {
        TAG_NONE = 2'b00,
        TAG_PRED = 2'b01,
        TAG_JOIN = 2'b10
    } jp_tag_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHADOW,
        ST_JOINED,
        ST_NULLIFY,
        ST_INSERT,
        ST_RECOVER
    } jp_state_e;

endpackage

// File: rtl/jp_qualify.sv
module jp_qualify #(
    parameter int MAX_PATH = 8,
    parameter int LEN_W    = 4
) (
    input  logic             dec_valid,
    input  logic             dec_cbr,
    input  logic [LEN_W-1:0] pred_len,
    input  logic [LEN_W-1:0] alt_len,
    output logic             start_ok
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_PATH);

    logic fits;

    always_comb begin
        fits     = (pred_len <= LIMIT) && (alt_len <= LIMIT);
        start_ok = dec_valid && dec_cbr && fits;
    end
endmodule

// File: rtl/jp_tag_window.sv
module jp_tag_window
    import jp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IW    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  jp_tag_e            wr_tag,
    output logic [2*DEPTH-1:0] tags_flat,
    output logic [DEPTH-1:0]   pred_mask
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        jp_tag_e tag_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= TAG_NONE;
            end else if (clr) begin
                tag_q <= TAG_NONE;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                tag_q <= wr_tag;
            end
        end

        assign tags_flat[2*i +: 2] = tag_q;
        assign pred_mask[i]        = (tag_q == TAG_PRED);
    end
endmodule

// File: rtl/jp_ctrl.sv
module jp_ctrl
    import jp_pkg::*;
#(
    parameter int LEN_W = 4,
    parameter int DEPTH = 16,
    parameter int IW    = 4,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic             dec_cbr,
    input  logic [LEN_W-1:0] pred_len,
    input  logic [LEN_W-1:0] alt_len,
    input  logic             start_ok,
    input  logic             res_valid,
    input  logic             res_mispredict,
    input  logic             ins_ack,
    output logic             clr,
    output logic             wr_en,
    output logic [IW-1:0]    wr_idx,
    output jp_tag_e          wr_tag,
    output logic             null_en,
    output logic             ins_req,
    output logic [LEN_W-1:0] ins_count,
    output logic             join_hold,
    output logic             full_recover
);
    jp_state_e        state, nxt;
    logic [CW-1:0]    cnt, cnt_n;
    logic [CW-1:0]    pl_q;
    logic [LEN_W-1:0] al_q;
    logic             load;

    // next state and slot writes
    always_comb begin
        nxt    = state;
        cnt_n  = cnt;
        wr_en  = 1'b0;
        wr_tag = TAG_NONE;
        load   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (res_valid && res_mispredict) begin
                    nxt = ST_RECOVER;
                end else if (start_ok) begin
                    load  = 1'b1;
                    cnt_n = '0;
                    nxt   = (pred_len == '0) ? ST_JOINED : ST_SHADOW;
                end
            end
            ST_SHADOW: begin
                if (res_valid) begin
                    nxt = res_mispredict ? ST_RECOVER : ST_IDLE;
                end else if (dec_valid && dec_cbr) begin
                    nxt = ST_RECOVER;
                end else if (dec_valid) begin
                    wr_en  = 1'b1;
                    wr_tag = TAG_PRED;
                    cnt_n  = cnt + CW'(1);
                    if (cnt + CW'(1) == pl_q) begin
                        nxt = ST_JOINED;
                    end
                end
            end
            ST_JOINED: begin
                if (res_valid) begin
                    nxt = res_mispredict ? ST_NULLIFY : ST_IDLE;
                end else if (dec_valid && (cnt < CW'(DEPTH))) begin
                    wr_en  = 1'b1;
                    wr_tag = TAG_JOIN;
                    cnt_n  = cnt + CW'(1);
                end
            end
            ST_NULLIFY: begin
                nxt = (al_q != '0) ? ST_INSERT : ST_IDLE;
            end
            ST_INSERT: begin
                if (ins_ack) begin
                    nxt = ST_IDLE;
                end
            end
            ST_RECOVER: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
        clr    = (nxt == ST_IDLE) || (nxt == ST_RECOVER);
        wr_idx = cnt[IW-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pl_q  <= '0;
            al_q  <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
            if (load) begin
                pl_q <= CW'(pred_len);
                al_q <= alt_len;
            end
        end
    end

    // outputs
    always_comb begin
        null_en      = (state == ST_NULLIFY);
        ins_req      = (state == ST_INSERT);
        join_hold    = (state == ST_NULLIFY) || (state == ST_INSERT);
        full_recover = (state == ST_RECOVER);
        ins_count    = (state == ST_INSERT) ? al_q : '0;
    end
endmodule

// File: rtl/jp_repair_tracker.sv
module jp_repair_tracker
    import jp_pkg::*;
#(
    parameter int MAX_PATH = 8,
    parameter int LEN_W    = 4,
    localparam int DEPTH   = 2 * MAX_PATH,
    localparam int IW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic               dec_cbr,
    input  logic [LEN_W-1:0]   dec_pred_len,
    input  logic [LEN_W-1:0]   dec_alt_len,
    input  logic               res_valid,
    input  logic               res_mispredict,
    input  logic               ins_ack,
    output logic [2*DEPTH-1:0] slot_tags,
    output logic [DEPTH-1:0]   nullify_mask,
    output logic               ins_req,
    output logic [LEN_W-1:0]   ins_count,
    output logic               join_hold,
    output logic               full_recover
);
    logic             start_ok;
    logic             clr;
    logic             wr_en;
    logic [IW-1:0]    wr_idx;
    jp_tag_e          wr_tag;
    logic             null_en;
    logic [DEPTH-1:0] pred_mask;

    jp_qualify #(.MAX_PATH(MAX_PATH), .LEN_W(LEN_W)) u_qualify (
        .dec_valid (dec_valid),
        .dec_cbr   (dec_cbr),
        .pred_len  (dec_pred_len),
        .alt_len   (dec_alt_len),
        .start_ok  (start_ok)
    );

    jp_ctrl #(.LEN_W(LEN_W), .DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec_valid      (dec_valid),
        .dec_cbr        (dec_cbr),
        .pred_len       (dec_pred_len),
        .alt_len        (dec_alt_len),
        .start_ok       (start_ok),
        .res_valid      (res_valid),
        .res_mispredict (res_mispredict),
        .ins_ack        (ins_ack),
        .clr            (clr),
        .wr_en          (wr_en),
        .wr_idx         (wr_idx),
        .wr_tag         (wr_tag),
        .null_en        (null_en),
        .ins_req        (ins_req),
        .ins_count      (ins_count),
        .join_hold      (join_hold),
        .full_recover   (full_recover)
    );

    jp_tag_window #(.DEPTH(DEPTH), .IW(IW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .tags_flat (slot_tags),
        .pred_mask (pred_mask)
    );

    assign nullify_mask = null_en ? pred_mask : '0;
endmodule

// File: rtl/jp_repair_tracker_chk.sv
module jp_repair_tracker_chk #(
    parameter int MAX_PATH = 8,
    parameter int LEN_W    = 4,
    localparam int DEPTH   = 2 * MAX_PATH
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dec_valid,
    input logic               dec_cbr,
    input logic [LEN_W-1:0]   dec_pred_len,
    input logic [LEN_W-1:0]   dec_alt_len,
    input logic               res_valid,
    input logic               res_mispredict,
    input logic               ins_ack,
    input logic [2*DEPTH-1:0] slot_tags,
    input logic [DEPTH-1:0]   nullify_mask,
    input logic               ins_req,
    input logic [LEN_W-1:0]   ins_count,
    input logic               join_hold,
    input logic               full_recover
);
    logic bad_code;

    always_comb begin
        bad_code = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            bad_code = bad_code | (&slot_tags[2*i +: 2]);
        end
    end

    // R2
    tag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_code);

    // R4
    nullify_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nullify_mask) |-> join_hold);

    // R4
    nullify_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nullify_mask) |=> (nullify_mask == '0));

    // R5
    ins_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !ins_ack) |=> (ins_req && $stable(ins_count)));

    // R5
    ins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req |-> join_hold);

    // R6
    ins_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_req |-> (ins_count != '0));

    // R7
    recover_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_recover |-> (nullify_mask == '0 && !ins_req && !join_hold
                          && slot_tags == '0));
endmodule

bind jp_repair_tracker jp_repair_tracker_chk #(
    .MAX_PATH (MAX_PATH),
    .LEN_W    (LEN_W)
) i_chk (.*);

// File: tb/test_jp_repair_tracker.sv
`timescale 1ns/1ps
module test_jp_repair_tracker;

    typedef struct {
        logic [31:0] tags;
        logic [15:0] nul;
        logic        req;
        logic [3:0]  cnt;
        logic        hold;
        logic        fr;
        string       rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0, dec_cbr = 1'b0;
    logic [3:0]  dec_pred_len = '0, dec_alt_len = '0;
    logic        res_valid = 1'b0, res_mispredict = 1'b0, ins_ack = 1'b0;
    logic [31:0] slot_tags;
    logic [15:0] nullify_mask;
    logic        ins_req;
    logic [3:0]  ins_count;
    logic        join_hold;
    logic        full_recover;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    jp_repair_tracker i_jp_repair_tracker (
        .clk, .rst_n, .dec_valid, .dec_cbr, .dec_pred_len, .dec_alt_len,
        .res_valid, .res_mispredict, .ins_ack, .slot_tags, .nullify_mask,
        .ins_req, .ins_count, .join_hold, .full_recover
    );

    function automatic logic [31:0] tg(int np, int nj);
        logic [31:0] t = '0;
        for (int i = 0; i < np; i++) t[2*i +: 2] = 2'b01;
        for (int j = 0; j < nj; j++) if (np + j < 16) t[2*(np+j) +: 2] = 2'b10;
        return t;
    endfunction

    function automatic exp_t ex(logic [31:0] t, logic [15:0] n, logic r,
                                logic [3:0] c, logic h, logic f, string rq);
        exp_t e;
        e.tags = t; e.nul = n; e.req = r; e.cnt = c; e.hold = h; e.fr = f; e.rq = rq;
        return e;
    endfunction

    task automatic drv(logic v, logic b, logic [3:0] pl, logic [3:0] al,
                       logic rv, logic rm, logic ak);
        dec_valid = v; dec_cbr = b; dec_pred_len = pl; dec_alt_len = al;
        res_valid = rv; res_mispredict = rm; ins_ack = ak;
    endtask

    task automatic idle();
        drv(0, 0, 0, 0, 0, 0, 0);
    endtask

    // driver: one edge, then push what must be visible after it
    task automatic tick(exp_t e);
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            logic [55:0] got, want;
            e = q.pop_front();
            got  = {slot_tags, nullify_mask, ins_req, ins_count, join_hold, full_recover};
            want = {e.tags, e.nul, e.req, e.cnt, e.hold, e.fr};
            checks++;
            if (got !== want) begin
                errors++;
                $display("FAIL %s tags=%h nul=%h req=%b cnt=%0d hold=%b fr=%b expected tags=%h nul=%h req=%b cnt=%0d hold=%b fr=%b",
                         e.rq, slot_tags, nullify_mask, ins_req, ins_count, join_hold,
                         full_recover, e.tags, e.nul, e.req, e.cnt, e.hold, e.fr);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick(ex(0, 0, 0, 0, 0, 0, "R1"));

        // R2 R3 R4 R5: predicted 3, alternate 2
        drv(1, 1, 3, 2, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R2"));
        for (int k = 1; k <= 3; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(k, 0), 0, 0, 0, 0, 0, "R2"));
        end
        for (int k = 1; k <= 2; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(3, k), 0, 0, 0, 0, 0, "R3"));
        end
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(tg(3, 2), 16'h0007, 0, 0, 1, 0, "R4"));
        idle();                   tick(ex(tg(3, 2), 0, 1, 2, 1, 0, "R5"));
        tick(ex(tg(3, 2), 0, 1, 2, 1, 0, "R5"));
        drv(0, 0, 0, 0, 0, 0, 1); tick(ex(0, 0, 0, 0, 0, 0, "R5"));
        idle();

        // R6: empty alternate path
        drv(1, 1, 2, 0, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R6"));
        for (int k = 1; k <= 2; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(k, 0), 0, 0, 0, 0, 0, "R6"));
        end
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(tg(2, 0), 16'h0003, 0, 0, 1, 0, "R6"));
        idle();                   tick(ex(0, 0, 0, 0, 0, 0, "R6"));

        // R7: mispredict before the meeting point
        drv(1, 1, 4, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R7"));
        for (int k = 1; k <= 2; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(k, 0), 0, 0, 0, 0, 0, "R7"));
        end
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(0, 0, 0, 0, 0, 1, "R7"));
        idle();                   tick(ex(0, 0, 0, 0, 0, 0, "R7"));

        // R8: second branch in the shadow
        drv(1, 1, 4, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R8"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(1, 0), 0, 0, 0, 0, 0, "R8"));
        drv(1, 1, 2, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 1, "R8"));
        idle();                   tick(ex(0, 0, 0, 0, 0, 0, "R8"));

        // R9: too long, not tracked
        drv(1, 1, 9, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R9"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R9"));
        drv(1, 1, 2, 9, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R9"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R9"));
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(0, 0, 0, 0, 0, 1, "R9"));
        idle();                   tick(ex(0, 0, 0, 0, 0, 0, "R9"));

        // R11: mispredict while idle
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(0, 0, 0, 0, 0, 1, "R11"));
        idle();                   tick(ex(0, 0, 0, 0, 0, 0, "R11"));

        // R10: correct resolves after and before the meeting point
        drv(1, 1, 2, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R10"));
        for (int k = 1; k <= 2; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(k, 0), 0, 0, 0, 0, 0, "R10"));
        end
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(2, 1), 0, 0, 0, 0, 0, "R10"));
        drv(0, 0, 0, 0, 1, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R10"));
        drv(1, 1, 3, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R10"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(1, 0), 0, 0, 0, 0, 0, "R10"));
        drv(0, 0, 0, 0, 1, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R10"));

        // R13: empty predicted path
        drv(1, 1, 0, 3, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R13"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(0, 1), 0, 0, 0, 0, 0, "R13"));
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(tg(0, 1), 0, 0, 0, 1, 0, "R13"));
        drv(0, 0, 0, 0, 0, 0, 1); tick(ex(tg(0, 1), 0, 1, 3, 1, 0, "R13"));
        tick(ex(0, 0, 0, 0, 0, 0, "R13"));
        idle();

        // R12: traffic during a pending insert
        drv(1, 1, 1, 2, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R12"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(1, 0), 0, 0, 0, 0, 0, "R12"));
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(tg(1, 0), 16'h0001, 0, 0, 1, 0, "R12"));
        idle();                   tick(ex(tg(1, 0), 0, 1, 2, 1, 0, "R12"));
        drv(1, 1, 1, 1, 1, 1, 0); tick(ex(tg(1, 0), 0, 1, 2, 1, 0, "R12"));
        drv(0, 0, 0, 0, 0, 0, 1); tick(ex(0, 0, 0, 0, 0, 0, "R12"));
        drv(1, 0, 0, 0, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R12"));

        // R3 R4: full window, join count stops at slot 15
        drv(1, 1, 8, 1, 0, 0, 0); tick(ex(0, 0, 0, 0, 0, 0, "R3"));
        for (int k = 1; k <= 8; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(k, 0), 0, 0, 0, 0, 0, "R2"));
        end
        for (int k = 1; k <= 10; k++) begin
            drv(1, 0, 0, 0, 0, 0, 0); tick(ex(tg(8, k), 0, 0, 0, 0, 0, "R3"));
        end
        drv(0, 0, 0, 0, 1, 1, 0); tick(ex(tg(8, 8), 16'h00FF, 0, 0, 1, 0, "R4"));
        idle();                   tick(ex(tg(8, 8), 0, 1, 1, 1, 0, "R5"));
        drv(0, 0, 0, 0, 0, 0, 1); tick(ex(0, 0, 0, 0, 0, 0, "R5"));
        idle();

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule